// File: doc/BRIEF.md
# Shared Flash Pump Power Controller

This block sets the power state of one charge pump that two flash controllers share, and of the two flash banks, one per controller. Each bank is in one of three power modes: sleep, standby or active. The pump is either asleep or active. A bank wakes when it is accessed or when its configured mode rises above sleep. Each bank has its own wake-up timer, so the two banks and the pump wake independently of each other. The pump wakes when any access or command arrives, and also whenever any bank leaves sleep. After the wake event a programmable count is loaded into a down-counter. That counter steps on every other system clock, and the pump turns active once the count has run out.

Only one controller at a time may own the pump. The owner's power-down strobe and the owner's sleep count are the ones the pump uses. When no controller owns the pump, no power-down is possible, and controller 0's count is used. A power-down takes two steps. The strobe arms the request. The pump then sleeps on the next cycle only if no access arrives in that cycle and every bank is asleep; otherwise the request is dropped. An access is held with a not-ready handshake until both the pump and the target bank are active.

Top module: `fpump_pwr_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, both pump-ready bits are 0, no grant is given, and both banks report sleep. Bank power is coded as sleep=0, standby=1, active=2, waking=3, in `bank_pwr[1:0]` for bank 0 and `bank_pwr[3:2]` for bank 1.
- R2: A read to either bank while the pump sleeps starts a pump wake with count N. Counting the wake edge as edge 1, pump-ready is first seen high after edge 2N+2 or 2N+3.
- R3: The two pump-ready bits are always equal. Both at 0 means the pump sleeps, and both at 1 means it is active.
- R4: While any bank is in standby, waking or active, a power-down strobe from the owner leaves the pump active.
- R5: At most one controller holds a grant. Requests arriving in the same cycle while the pump is free go to controller 0. A request made while the other controller holds the grant waits until that controller drops its request, and the grant then passes over in the next cycle.
- R6: A power-down strobe from the controller that does not own the pump is ignored. The wake count that applies is the owner's.
- R7: An owner strobe arms a power-down. The pump sleeps one cycle later if no read or command arrives in that cycle and all banks sleep. If an access does arrive in that cycle, the power-down is aborted and the pump stays active.
- R8: `acc_rdy[i]` is high only while controller i has a read or command pending, the pump is active and bank i is active. Pending accesses are stalled during any wake.
- R9: A bank wakes from sleep on its own timer of BANK_SLP_CYC+1 cycles, and from standby on a timer of BANK_SBY_CYC+1 cycles (active after edge L+2, counting the wake edge as 1). A wake of one bank leaves the other bank in its current mode.
- R10: When an active bank has no access pending, it falls in the next cycle to the mode given by its 2-bit setting: 0 for sleep, 1 for standby, 2 or 3 for active.
- R11: A wake count of zero makes the pump active on the first enabled clock after the wake event, which is after edge 2 or 3.
- R12: A program or erase command wakes both its bank and the pump, exactly as a read does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_req | input | 2 | Per-controller pump ownership request (level, held while owning) |
| own_gnt | output | 2 | Per-controller ownership grant |
| pd_go | input | 2 | Per-controller one-cycle pump power-down strobe |
| sleep_cnt | input | 2*PW | Per-controller pump wake count, controller i in bits [PW*i +: PW] |
| bank_cfg | input | 4 | Per-bank configured power mode, 2 bits each |
| rd_vld | input | 2 | Per-controller read request to its bank (held until accepted) |
| cmd_vld | input | 2 | Per-controller program/erase command (held until accepted) |
| acc_rdy | output | 2 | Per-controller access accepted this cycle |
| pump_rdy | output | 2 | Per-controller copy of pump active status |
| bank_pwr | output | 4 | Per-bank power mode, 2 bits each |

## Verification
The checker assumes that a controller keeps its read or command asserted until `acc_rdy` accepts it, that power-down strobes last exactly one cycle, and that the sleep counts and bank settings change only while no wake that uses them is in progress. The bench drives all inputs on the falling edge. It holds every access until it sees it accepted, raises each strobe for a single cycle, and writes new counts or bank settings only while the pump and banks are idle. Wake latencies are checked against windows two cycles wide, because the half-rate enable may have either phase when the wake event arrives.

// File: rtl/fpp_pkg.sv
// Package: shared constants, state types and the bank-setting decode used by
// the shared flash pump power controller. Assumes exactly two controllers.
package fpp_pkg;

    localparam int NCTL = 2;

    typedef enum logic [1:0] {
        BP_SLEEP  = 2'd0,
        BP_STBY   = 2'd1,
        BP_ACTIVE = 2'd2,
        BP_WAKING = 2'd3
    } bank_pwr_e;

    typedef enum logic [1:0] {
        PS_SLEEP  = 2'd0,
        PS_WAKE   = 2'd1,
        PS_ACTIVE = 2'd2,
        PS_PDARM  = 2'd3
    } pump_st_e;

    // Map a 2-bit bank setting onto the mode it asks for.
    function automatic bank_pwr_e cfg_goal(input logic [1:0] c);
        case (c)
            2'b00:   return BP_SLEEP;
            2'b01:   return BP_STBY;
            default: return BP_ACTIVE;
        endcase
    endfunction

endpackage

// File: rtl/fpp_own_arb.sv
// Ownership arbiter: grants the shared pump to one controller at a time.
// Assumes requests are levels held for as long as ownership is wanted.
// A free pump goes to controller 0 on a tie. A holder keeps the grant while
// it requests; on release the grant passes straight to the other requester.
module fpp_own_arb
    import fpp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCTL-1:0] req,
    output logic [NCTL-1:0] gnt,
    output logic            owner,
    output logic            owner_vld
);

    logic [NCTL-1:0] gnt_q;
    logic [NCTL-1:0] gnt_d;

    // Next grant: keep the holder, hand over on release, fixed priority when free.
    always_comb begin
        gnt_d = gnt_q;
        if (gnt_q[0]) begin
            if (!req[0]) gnt_d = req[1] ? 2'b10 : 2'b00;
        end else if (gnt_q[1]) begin
            if (!req[1]) gnt_d = req[0] ? 2'b01 : 2'b00;
        end else if (req[0]) begin
            gnt_d = 2'b01;
        end else if (req[1]) begin
            gnt_d = 2'b10;
        end
    end

    // Grant register.
    always_ff @(posedge clk) begin
        if (!rst_n) gnt_q <= '0;
        else        gnt_q <= gnt_d;
    end

    assign gnt       = gnt_q;
    assign owner     = gnt_q[1];
    assign owner_vld = |gnt_q;

endmodule

// File: rtl/fpp_half_en.sv
// Half-rate enable: a pulse on every second system clock, which steps the
// pump wake counter. Free-running from reset; its phase is not otherwise
// tied to any event.
module fpp_half_en (
    input  logic clk,
    input  logic rst_n,
    output logic en
);

    logic ph_q;

    // Phase toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    assign en = ph_q;

endmodule

// File: rtl/fpp_bank_tmr.sv
// Per-bank power sequencer with its own wake timer. Wakes to active on an
// access or when the setting asks for more than sleep; falls back to the
// configured mode once idle. Assumes accesses are held until accepted.
module fpp_bank_tmr
    import fpp_pkg::*;
#(
    parameter int SLP_CYC = 12,
    parameter int SBY_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg,
    input  logic       touch,
    output bank_pwr_e  pwr
);

    localparam int MAXC = (SLP_CYC > SBY_CYC) ? SLP_CYC : SBY_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LD_SLP = CW'(SLP_CYC);
    localparam logic [CW-1:0] LD_SBY = CW'(SBY_CYC);

    bank_pwr_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    bank_pwr_e     goal;

    assign goal = cfg_goal(cfg);

    // Next state and timer value.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            BP_SLEEP: begin
                if (touch || goal != BP_SLEEP) begin
                    st_d  = BP_WAKING;
                    cnt_d = LD_SLP;
                end
            end
            BP_STBY: begin
                if (touch || goal == BP_ACTIVE) begin
                    st_d  = BP_WAKING;
                    cnt_d = LD_SBY;
                end else if (goal == BP_SLEEP) begin
                    st_d = BP_SLEEP;
                end
            end
            BP_ACTIVE: begin
                if (!touch && goal != BP_ACTIVE) st_d = goal;
            end
            default: begin
                if (cnt_q == '0) st_d  = BP_ACTIVE;
                else             cnt_d = cnt_q - 1'b1;
            end
        endcase
    end

    // State and timer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BP_SLEEP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign pwr = st_q;

endmodule

// File: rtl/fpp_pump_seq.sv
// Pump sequencer: sleep/active control of the shared pump. Wakes on any
// access or any bank not asleep, then waits for a loaded count to run out on
// the half-rate enable. Power-down is two-step: arm, then sleep only if the
// next cycle has no access and all banks are asleep.
module fpp_pump_seq
    import fpp_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_half,
    input  logic          any_acc,
    input  logic          all_sleep,
    input  logic          pd_eff,
    input  logic [PW-1:0] wake_cnt,
    output logic          pump_on
);

    pump_st_e      st_q, st_d;
    logic [PW-1:0] cnt_q, cnt_d;
    logic          wake_evt;

    assign wake_evt = any_acc || !all_sleep;

    // Next state and down-counter value.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            PS_SLEEP: begin
                if (wake_evt) begin
                    st_d  = PS_WAKE;
                    cnt_d = wake_cnt;
                end
            end
            PS_WAKE: begin
                if (en_half) begin
                    if (cnt_q == '0) st_d  = PS_ACTIVE;
                    else             cnt_d = cnt_q - 1'b1;
                end
            end
            PS_ACTIVE: begin
                if (pd_eff) st_d = PS_PDARM;
            end
            default: begin
                if (wake_evt) st_d = PS_ACTIVE;
                else          st_d = PS_SLEEP;
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PS_SLEEP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign pump_on = (st_q == PS_ACTIVE) || (st_q == PS_PDARM);

endmodule

// File: rtl/fpump_pwr_ctl.sv
// Top: shared flash pump power controller for two controllers, each owning
// one bank. Routes the owner's strobe and count to the pump sequencer,
// instantiates one timer per bank, and forms the per-controller handshake.
// Assumes a controller only accesses its own bank.
module fpump_pwr_ctl
    import fpp_pkg::*;
#(
    parameter int PW           = 8,
    parameter int BANK_SLP_CYC = 12,
    parameter int BANK_SBY_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCTL-1:0]      own_req,
    output logic [NCTL-1:0]      own_gnt,
    input  logic [NCTL-1:0]      pd_go,
    input  logic [NCTL*PW-1:0]   sleep_cnt,
    input  logic [2*NCTL-1:0]    bank_cfg,
    input  logic [NCTL-1:0]      rd_vld,
    input  logic [NCTL-1:0]      cmd_vld,
    output logic [NCTL-1:0]      acc_rdy,
    output logic [NCTL-1:0]      pump_rdy,
    output logic [2*NCTL-1:0]    bank_pwr
);

    logic            owner;
    logic            owner_vld;
    logic            en_half;
    logic            pump_on;
    logic            pd_eff;
    logic [PW-1:0]   wake_cnt;
    logic [NCTL-1:0] touch;
    logic [NCTL-1:0] bank_asleep;
    logic [NCTL-1:0] bank_up;

    fpp_own_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (own_req),
        .gnt       (own_gnt),
        .owner     (owner),
        .owner_vld (owner_vld)
    );

    fpp_half_en u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_half)
    );

    // Owner selection of strobe and wake count.
    always_comb begin
        pd_eff   = owner_vld && pd_go[owner];
        wake_cnt = sleep_cnt[PW*owner +: PW];
    end

    for (genvar i = 0; i < NCTL; i++) begin : g_bank
        bank_pwr_e pwr_i;

        assign touch[i] = rd_vld[i] || cmd_vld[i];

        fpp_bank_tmr #(
            .SLP_CYC (BANK_SLP_CYC),
            .SBY_CYC (BANK_SBY_CYC)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (bank_cfg[2*i +: 2]),
            .touch (touch[i]),
            .pwr   (pwr_i)
        );

        assign bank_pwr[2*i +: 2] = pwr_i;
        assign bank_asleep[i]     = (pwr_i == BP_SLEEP);
        assign bank_up[i]         = (pwr_i == BP_ACTIVE);
        assign acc_rdy[i]         = touch[i] && pump_on && bank_up[i];
        assign pump_rdy[i]        = pump_on;
    end

    fpp_pump_seq #(
        .PW (PW)
    ) u_pump (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_half   (en_half),
        .any_acc   (|touch),
        .all_sleep (&bank_asleep),
        .pd_eff    (pd_eff),
        .wake_cnt  (wake_cnt),
        .pump_on   (pump_on)
    );

endmodule

// File: rtl/fpump_pwr_chk.sv
// Checker for the shared flash pump power controller, bound to the top.
// Assumes accesses are held until accepted and strobes last one cycle.
module fpump_pwr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] own_req,
    input logic [1:0] own_gnt,
    input logic [3:0] bank_cfg,
    input logic [1:0] rd_vld,
    input logic [1:0] cmd_vld,
    input logic [1:0] acc_rdy,
    input logic [1:0] pump_rdy,
    input logic [3:0] bank_pwr
);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pump_rdy == 2'b00 && own_gnt == 2'b00 && bank_pwr == 4'h0));

    a_r3_rdy_match: assert property (@(posedge clk) disable iff (!rst_n)
        pump_rdy[0] == pump_rdy[1]);

    a_r4_sleep_needs_idle_banks: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_rdy[0]) |-> $past(bank_pwr == 4'h0));

    a_r5_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(own_gnt));

    a_r5_tie_to_ctl0: assert property (@(posedge clk) disable iff (!rst_n)
        (own_req == 2'b11 && own_gnt == 2'b00) |=> own_gnt == 2'b01);

    a_r5_holder_keeps0: assert property (@(posedge clk) disable iff (!rst_n)
        (own_gnt[0] && own_req[0]) |=> own_gnt[0]);

    a_r5_holder_keeps1: assert property (@(posedge clk) disable iff (!rst_n)
        (own_gnt[1] && own_req[1]) |=> own_gnt[1]);

    a_r7_no_sleep_on_access: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_rdy[0]) |-> $past(rd_vld == 2'b00 && cmd_vld == 2'b00));

    a_r8_stall_while_pump_down: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_rdy[0] |-> acc_rdy == 2'b00);

    a_r9_bank0_stays_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_pwr[1:0] == 2'd0 && !rd_vld[0] && !cmd_vld[0] && bank_cfg[1:0] == 2'd0)
        |=> bank_pwr[1:0] == 2'd0);

    a_r9_bank1_stays_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_pwr[3:2] == 2'd0 && !rd_vld[1] && !cmd_vld[1] && bank_cfg[3:2] == 2'd0)
        |=> bank_pwr[3:2] == 2'd0);

endmodule

bind fpump_pwr_ctl fpump_pwr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_req  (own_req),
    .own_gnt  (own_gnt),
    .bank_cfg (bank_cfg),
    .rd_vld   (rd_vld),
    .cmd_vld  (cmd_vld),
    .acc_rdy  (acc_rdy),
    .pump_rdy (pump_rdy),
    .bank_pwr (bank_pwr)
);

// File: tb/sim_fpump_pwr_ctl.sv
// Directed bench for the shared flash pump power controller.
module sim_fpump_pwr_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int PW         = 8;
    localparam int SLP        = 12;
    localparam int SBY        = 4;
    localparam int WDOG       = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    own_req = '0;
    logic [1:0]    own_gnt;
    logic [1:0]    pd_go = '0;
    logic [2*PW-1:0] sleep_cnt = '0;
    logic [3:0]    bank_cfg = '0;
    logic [1:0]    rd_vld = '0;
    logic [1:0]    cmd_vld = '0;
    logic [1:0]    acc_rdy;
    logic [1:0]    pump_rdy;
    logic [3:0]    bank_pwr;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    fpump_pwr_ctl #(.PW(PW), .BANK_SLP_CYC(SLP), .BANK_SBY_CYC(SBY)) u0 (
        .clk(clk), .rst_n(rst_n), .own_req(own_req), .own_gnt(own_gnt),
        .pd_go(pd_go), .sleep_cnt(sleep_cnt), .bank_cfg(bank_cfg),
        .rd_vld(rd_vld), .cmd_vld(cmd_vld), .acc_rdy(acc_rdy),
        .pump_rdy(pump_rdy), .bank_pwr(bank_pwr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is counted as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // One-cycle strobe on the given controller's power-down input.
    task automatic strobe(input int c);
        pd_go[c] = 1'b1;
        tick();
        pd_go[c] = 1'b0;
    endtask

    // Hold an access on controller c; report the edge counts at which pump,
    // bank and acceptance are first seen, plus handshake/independence faults.
    task automatic access_wait(input int c, input bit is_cmd,
                               output int p, output int b, output int a,
                               output int bad8, output int bad9);
        p = 0; b = 0; a = 0; bad8 = 0; bad9 = 0;
        if (is_cmd) cmd_vld[c] = 1'b1;
        else        rd_vld[c]  = 1'b1;
        for (int k = 1; k < 1000; k++) begin
            tick();
            if (pump_rdy[0] && p == 0) p = k;
            if (bank_pwr[2*c +: 2] == 2'd2 && b == 0) b = k;
            if (acc_rdy[c] && !(pump_rdy[0] && bank_pwr[2*c +: 2] == 2'd2)) bad8++;
            if (bank_pwr[2*(1-c) +: 2] != 2'd0) bad9++;
            if (pump_rdy[0] != pump_rdy[1]) bad8++;
            if (acc_rdy[c]) begin
                a = k;
                break;
            end
        end
        rd_vld[c]  = 1'b0;
        cmd_vld[c] = 1'b0;
    endtask

    task automatic t_reset();
        check(pump_rdy == 2'b00, "R1 pump ready after reset", pump_rdy, 0);
        check(own_gnt == 2'b00, "R1 grant after reset", own_gnt, 0);
        check(bank_pwr == 4'h0, "R1 banks after reset", bank_pwr, 0);
    endtask

    task automatic t_own();
        own_req = 2'b11; tick();
        check(own_gnt == 2'b01, "R5 tie goes to controller 0", own_gnt, 1);
        own_req = 2'b10; tick();
        check(own_gnt == 2'b10, "R5 handover on release", own_gnt, 2);
        own_req = 2'b11; tick();
        check(own_gnt == 2'b10, "R5 request stalled while held", own_gnt, 2);
        own_req = 2'b01; tick();
        check(own_gnt == 2'b01, "R5 stalled request granted", own_gnt, 1);
        own_req = 2'b00; tick();
        check(own_gnt == 2'b00, "R5 release", own_gnt, 0);
    endtask

    task automatic t_wake_read();
        int p, b, a, bad8, bad9;
        sleep_cnt[PW-1:0] = 8'd5;
        access_wait(0, 1'b0, p, b, a, bad8, bad9);
        check(p >= 12 && p <= 13, "R2 pump wake latency", p, 12);
        check(b == SLP + 2, "R9 bank wake from sleep", b, SLP + 2);
        check(a == 14, "R8 accepted when both ready", a, 14);
        check(bad8 == 0, "R8 R3 handshake and ready copies", bad8, 0);
        check(bad9 == 0, "R9 other bank untouched", bad9, 0);
        tick();
        check(bank_pwr[1:0] == 2'd0, "R10 idle bank falls to sleep", bank_pwr[1:0], 0);
        check(pump_rdy[0] == 1'b1, "R2 pump stays active", pump_rdy[0], 1);
    endtask

    task automatic t_nonowner();
        own_req = 2'b01; tick();
        strobe(1);
        tick(); tick(); tick();
        check(pump_rdy[0] == 1'b1, "R6 non-owner strobe ignored", pump_rdy[0], 1);
    endtask

    task automatic t_pd_abort();
        int p, b, a, bad8, bad9;
        pd_go[0] = 1'b1; tick();
        pd_go[0] = 1'b0;
        access_wait(1, 1'b0, p, b, a, bad8, bad9);
        check(p == 1, "R7 access aborts power-down", p, 1);
        tick(); tick(); tick();
        check(pump_rdy[0] == 1'b1, "R7 abort leaves pump active", pump_rdy[0], 1);
    endtask

    task automatic t_pd_ok();
        pd_go[0] = 1'b1; tick();
        pd_go[0] = 1'b0;
        check(pump_rdy[0] == 1'b1, "R7 armed pump still active", pump_rdy[0], 1);
        tick();
        check(pump_rdy == 2'b00, "R7 R3 pump asleep", pump_rdy, 0);
    endtask

    task automatic t_owner_count();
        int p, b, a, bad8, bad9;
        sleep_cnt[2*PW-1:PW] = 8'd1;
        own_req = 2'b10; tick();
        check(own_gnt == 2'b10, "R5 controller 1 owns", own_gnt, 2);
        access_wait(1, 1'b0, p, b, a, bad8, bad9);
        check(p >= 4 && p <= 5, "R6 owner count applies", p, 4);
        check(b == SLP + 2 && bad9 == 0, "R9 bank 1 wake", b, SLP + 2);
        tick();
    endtask

    task automatic t_zero_count();
        int p, b, a, bad8, bad9;
        sleep_cnt[2*PW-1:PW] = 8'd0;
        strobe(1); tick();
        check(pump_rdy[0] == 1'b0, "R7 owner 1 puts pump to sleep", pump_rdy[0], 0);
        access_wait(1, 1'b0, p, b, a, bad8, bad9);
        check(p >= 2 && p <= 3, "R11 zero count wake", p, 2);
        tick();
    endtask

    task automatic t_bank_hold();
        int p, b, a, bad8, bad9;
        bank_cfg[1:0] = 2'b10;
        for (int k = 0; k < 40; k++) tick();
        check(bank_pwr[1:0] == 2'd2, "R10 bank follows active setting", bank_pwr[1:0], 2);
        strobe(1); tick(); tick(); tick();
        check(pump_rdy[0] == 1'b1, "R4 active bank holds pump", pump_rdy[0], 1);
        bank_cfg[1:0] = 2'b01; tick();
        check(bank_pwr[1:0] == 2'd1, "R10 bank drops to standby", bank_pwr[1:0], 1);
        strobe(1); tick(); tick(); tick();
        check(pump_rdy[0] == 1'b1, "R4 standby bank holds pump", pump_rdy[0], 1);
        access_wait(0, 1'b0, p, b, a, bad8, bad9);
        check(b == SBY + 2, "R9 bank wake from standby", b, SBY + 2);
        bank_cfg[1:0] = 2'b00; tick();
        check(bank_pwr[1:0] == 2'd0, "R10 bank back to sleep", bank_pwr[1:0], 0);
        strobe(1); tick();
        check(pump_rdy[0] == 1'b0, "R4 pump sleeps once banks sleep", pump_rdy[0], 0);
    endtask

    task automatic t_cmd();
        int p, b, a, bad8, bad9;
        access_wait(0, 1'b1, p, b, a, bad8, bad9);
        check(p >= 2 && p <= 3, "R12 command wakes pump", p, 2);
        check(b == SLP + 2 && a == SLP + 2, "R12 command wakes bank", b, SLP + 2);
        check(bad8 == 0, "R12 handshake on command", bad8, 0);
    endtask

    initial begin
        @(negedge clk); tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_own();
        t_wake_read();
        t_nonowner();
        t_pd_abort();
        t_pd_ok();
        t_owner_count();
        t_zero_count();
        t_bank_hold();
        t_cmd();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule